// File: doc/BRIEF.md
# Tamper Response Sequencer

This block collects tamper flags from the internal monitors (temperature, case switch, supply, battery, oscillator) and from a set of external digital sensor inputs. Each source has a mask bit and an erase-level field. When any unmasked source becomes active while no alarm is held, the block runs a fixed five-step response, one step per clock. It first wipes the internal key store and then the external RAM, the second only when external memory control is enabled. It then freezes the set of sources that fired into a latch register, raises an alert to the host, and copies a free-running time base into a stamp register.

The erase reach is a level. Level L wipes regions 0 through L, shown as a thermometer mask on the wipe strobes. The level chosen is the widest among all active unmasked sources. The host may also request an erase with a level of its own, without any tamper. That request runs only the two wipe steps. Once the alert is set, the latches and the alert stay frozen until the host issues a latch clear at a moment when no unmasked source is active. Sources that fire while a response runs, or while the alert is held, are added to the latches. They do not restart the response and do not move the stamp.

All pins are plain control and status levels. No data stream crosses the block's edge, so there is no handshake and no back-pressure.

Top module: `tamper_resp_seq`

## Requirements
- R1: After reset, key_wipe, ram_wipe, latch_q, alert, stamp_q and busy are all zero.
- R2: An unmasked active source, sampled at a clock edge while the block is idle and alert is low, starts a response. key_wipe is nonzero for exactly the one cycle that follows that edge.
- R3: ram_wipe carries the same mask as key_wipe, in the cycle right after key_wipe, and only when ext_mem_en is high; otherwise it stays zero.
- R4: From the fourth cycle after the trigger edge, latch_q holds every unmasked source that was active at the trigger edge or at any edge since. Internal sources occupy bits [N_INT-1:0] and external sources occupy the bits above them.
- R5: alert rises in the fifth cycle after the trigger edge and stays high until a latch clear is accepted.
- R6: stamp_q takes the value of timebase sampled at the sixth edge of the response (the trigger edge counts as the first). It changes at no other time. busy is high for the five cycles after the trigger edge.
- R7: The wipe mask sets bit r when r <= L. L is the largest level field among active unmasked sources, where the field of source i is src_level[i*LVL_W +: LVL_W]. When host_erase is sampled in the same edge, host_level also takes part in the maximum.
- R8: A source whose src_mask bit is 1 starts no response and never appears in latch_q.
- R9: host_erase, sampled while idle, runs only the key and RAM wipe steps at the requested level. busy is high for two cycles, and latch_q, alert and stamp_q are left unchanged.
- R10: A latch_clr sampled while any unmasked source is active, or while a response runs, is ignored: latch_q and alert keep their values. An accepted clear zeroes latch_q and alert.
- R11: A source that fires during a response, or while alert is held, is ORed into latch_q. It does not restart the response and does not change stamp_q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tamper_int | input | N_INT | Internal monitor flags, active high |
| tamper_ext | input | N_EXT | External sensor flags, active high |
| src_mask | input | N_SRC | 1 masks the source |
| src_level | input | N_SRC*LVL_W | Erase-level field per source |
| ext_mem_en | input | 1 | Enables the external RAM wipe step |
| host_erase | input | 1 | Host erase request |
| host_level | input | LVL_W | Level for a host erase |
| latch_clr | input | 1 | Latch and alert clear request |
| timebase | input | TS_W | Free-running time count |
| key_wipe | output | 2**LVL_W | Internal key region wipe strobes |
| ram_wipe | output | 2**LVL_W | External RAM region wipe strobes |
| latch_q | output | N_SRC | Frozen tamper sources |
| alert | output | 1 | Tamper alert to host |
| stamp_q | output | TS_W | Time stamp of the last response |
| busy | output | 1 | Response in progress |

## Verification
The hardest case to reach is a second source that fires while the first response is still in its wipe steps. It must be carried into the latches at the capture step without restarting the sequence or moving the stamp. The stimulus raises a second external source exactly two cycles after the trigger edge, holds it until the alert is up, and then checks the latch word and the stamp value recorded for the first event. A second hard case is a clear issued while a source is still held active. The bench provokes it by keeping a source asserted through a latch_clr pulse, releasing it, and clearing again.

// File: rtl/trs_pkg.sv
package trs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_KEY,
    ST_RAM,
    ST_CAP,
    ST_ALRT,
    ST_STMP
  } seq_st_e;
endpackage

// File: rtl/trs_src_resolve.sv
module trs_src_resolve #(
  parameter int N_SRC = 9,
  parameter int LVL_W = 2
) (
  input  logic [N_SRC-1:0]       raw,
  input  logic [N_SRC-1:0]       mask,
  input  logic [N_SRC*LVL_W-1:0] level,
  input  logic                   host_req,
  input  logic [LVL_W-1:0]       host_lvl,
  output logic [N_SRC-1:0]       act,
  output logic                   tamper_any,
  output logic [LVL_W-1:0]       lvl_max
);
  logic [LVL_W-1:0] lvl_g [N_SRC];

  assign act        = raw & ~mask;
  assign tamper_any = |act;

  for (genvar i = 0; i < N_SRC; i++) begin : g_lvl
    assign lvl_g[i] = act[i] ? level[i*LVL_W +: LVL_W] : '0;
  end

  always_comb begin
    lvl_max = host_req ? host_lvl : '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (lvl_g[i] > lvl_max) lvl_max = lvl_g[i];
    end
  end
endmodule

// File: rtl/trs_seq_fsm.sv
module trs_seq_fsm
  import trs_pkg::*;
#(
  parameter int LVL_W = 2,
  localparam int NREG = 2**LVL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tamper_go,
  input  logic             host_go,
  input  logic [LVL_W-1:0] lvl_in,
  input  logic             ext_mem_en,
  output seq_st_e          state,
  output logic [NREG-1:0]  key_wipe,
  output logic [NREG-1:0]  ram_wipe,
  output logic             busy
);
  seq_st_e          st_r;
  logic             tmp_r;
  logic [LVL_W-1:0] lvl_r;
  logic [NREG-1:0]  thermo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_r  <= ST_IDLE;
      tmp_r <= 1'b0;
      lvl_r <= '0;
    end else begin
      unique case (st_r)
        ST_IDLE: begin
          if (tamper_go || host_go) begin
            st_r  <= ST_KEY;
            tmp_r <= tamper_go;
            lvl_r <= lvl_in;
          end
        end
        ST_KEY:  st_r <= ST_RAM;
        ST_RAM:  st_r <= tmp_r ? ST_CAP : ST_IDLE;
        ST_CAP:  st_r <= ST_ALRT;
        ST_ALRT: st_r <= ST_STMP;
        ST_STMP: st_r <= ST_IDLE;
        default: st_r <= ST_IDLE;
      endcase
    end
  end

  for (genvar r = 0; r < NREG; r++) begin : g_thermo
    assign thermo[r] = (LVL_W'(r) <= lvl_r);
  end

  assign state    = st_r;
  assign busy     = (st_r != ST_IDLE);
  assign key_wipe = (st_r == ST_KEY) ? thermo : '0;
  assign ram_wipe = (st_r == ST_RAM && ext_mem_en) ? thermo : '0;

  // R3: the RAM wipe only ever follows a key wipe
  a_r3_ram_after_key: assert property (@(posedge clk) disable iff (!rst_n)
    (|ram_wipe) |-> $past(|key_wipe));
  // R7: wipe strobes form a thermometer mask from region 0
  a_r7_thermo_mask: assert property (@(posedge clk) disable iff (!rst_n)
    ((key_wipe & (key_wipe + NREG'(1))) == '0));
  // R2: a key wipe lasts one cycle
  a_r2_key_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (|key_wipe) |=> !(|key_wipe));
endmodule

// File: rtl/trs_latch_bank.sv
module trs_latch_bank
  import trs_pkg::*;
#(
  parameter int N_SRC = 9,
  parameter int TS_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  seq_st_e          state,
  input  logic             trig,
  input  logic [N_SRC-1:0] act,
  input  logic             latch_clr,
  input  logic [TS_W-1:0]  timebase,
  output logic [N_SRC-1:0] latch_q,
  output logic             alert,
  output logic [TS_W-1:0]  stamp_q
);
  logic [N_SRC-1:0] pend_r, latch_r;
  logic             alert_r;
  logic [TS_W-1:0]  stamp_r;
  logic             idle, clr_ok, frozen;

  assign idle   = (state == ST_IDLE);
  assign clr_ok = latch_clr && idle && (act == '0);
  assign frozen = alert_r || (state == ST_ALRT) || (state == ST_STMP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_r  <= '0;
      latch_r <= '0;
      alert_r <= 1'b0;
      stamp_r <= '0;
    end else begin
      if (idle) pend_r <= trig ? act : '0;
      else      pend_r <= pend_r | act;

      if (state == ST_CAP) latch_r <= latch_r | pend_r | act;
      else if (clr_ok)     latch_r <= '0;
      else if (frozen)     latch_r <= latch_r | act;

      if (state == ST_ALRT) alert_r <= 1'b1;
      else if (clr_ok)      alert_r <= 1'b0;

      if (state == ST_STMP) stamp_r <= timebase;
    end
  end

  assign latch_q = latch_r;
  assign alert   = alert_r;
  assign stamp_q = stamp_r;

  // R5: alert holds unless a clear is requested
  a_r5_alert_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (alert && !latch_clr) |=> alert);
  // R10: a clear with an active source leaves the alert up
  a_r10_clear_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (alert && (act != '0)) |=> alert);
  // R6: the stamp moves only at the stamp step
  a_r6_stamp_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_STMP) |=> $stable(stamp_q));
  // R11: latch bits are only lost through an idle clear request
  a_r11_latch_grows: assert property (@(posedge clk) disable iff (!rst_n)
    !(latch_clr && idle) |=> ((latch_q & $past(latch_q)) == $past(latch_q)));
endmodule

// File: rtl/tamper_resp_seq.sv
module tamper_resp_seq
  import trs_pkg::*;
#(
  parameter int N_INT = 5,
  parameter int N_EXT = 4,
  parameter int LVL_W = 2,
  parameter int TS_W  = 16,
  localparam int N_SRC = N_INT + N_EXT,
  localparam int NREG  = 2**LVL_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_INT-1:0]       tamper_int,
  input  logic [N_EXT-1:0]       tamper_ext,
  input  logic [N_SRC-1:0]       src_mask,
  input  logic [N_SRC*LVL_W-1:0] src_level,
  input  logic                   ext_mem_en,
  input  logic                   host_erase,
  input  logic [LVL_W-1:0]       host_level,
  input  logic                   latch_clr,
  input  logic [TS_W-1:0]        timebase,
  output logic [NREG-1:0]        key_wipe,
  output logic [NREG-1:0]        ram_wipe,
  output logic [N_SRC-1:0]       latch_q,
  output logic                   alert,
  output logic [TS_W-1:0]        stamp_q,
  output logic                   busy
);
  logic [N_SRC-1:0] act;
  logic             tamper_any, tamper_go;
  logic [LVL_W-1:0] lvl_max;
  seq_st_e          state;

  trs_src_resolve #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_resolve (
    .raw        ({tamper_ext, tamper_int}),
    .mask       (src_mask),
    .level      (src_level),
    .host_req   (host_erase),
    .host_lvl   (host_level),
    .act        (act),
    .tamper_any (tamper_any),
    .lvl_max    (lvl_max)
  );

  assign tamper_go = tamper_any && !alert;

  trs_seq_fsm #(.LVL_W(LVL_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .tamper_go  (tamper_go),
    .host_go    (host_erase),
    .lvl_in     (lvl_max),
    .ext_mem_en (ext_mem_en),
    .state      (state),
    .key_wipe   (key_wipe),
    .ram_wipe   (ram_wipe),
    .busy       (busy)
  );

  trs_latch_bank #(.N_SRC(N_SRC), .TS_W(TS_W)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .trig      (tamper_go && state == ST_IDLE),
    .act       (act),
    .latch_clr (latch_clr),
    .timebase  (timebase),
    .latch_q   (latch_q),
    .alert     (alert),
    .stamp_q   (stamp_q)
  );

  // R8: masked sources never reach the latches
  a_r8_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    ((latch_q & src_mask) == '0) |=> ((latch_q & src_mask) == '0 || $past(src_mask) != src_mask));
endmodule

// File: tb/test_tamper_resp_seq.sv
module test_tamper_resp_seq;
  localparam int N_INT = 5, N_EXT = 4, LVL_W = 2, TS_W = 16;
  localparam int N_SRC = N_INT + N_EXT, NREG = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N_SRC-1:0] tin = '0, mask = '0;
  logic [N_SRC*LVL_W-1:0] lvl_cfg;
  logic ext_en = 1'b1, herase = 1'b0, lclr = 1'b0;
  logic [LVL_W-1:0] hlvl = '0;
  logic [TS_W-1:0] tbv = '0;
  logic [NREG-1:0] key_wipe, ram_wipe;
  logic [N_SRC-1:0] latch_q;
  logic alert, busy;
  logic [TS_W-1:0] stamp_q;

  int vecs = 0, errs = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;
  always @(negedge clk) tbv <= tbv + 1'b1;

  tamper_resp_seq #(.N_INT(N_INT), .N_EXT(N_EXT), .LVL_W(LVL_W), .TS_W(TS_W)) i_tamper_resp_seq (
    .clk(clk), .rst_n(rst_n), .tamper_int(tin[N_INT-1:0]), .tamper_ext(tin[N_SRC-1:N_INT]),
    .src_mask(mask), .src_level(lvl_cfg), .ext_mem_en(ext_en), .host_erase(herase),
    .host_level(hlvl), .latch_clr(lclr), .timebase(tbv), .key_wipe(key_wipe),
    .ram_wipe(ram_wipe), .latch_q(latch_q), .alert(alert), .stamp_q(stamp_q), .busy(busy));

  // behavioural reference
  int m_step = 0;
  logic m_tmp = 0, m_alert = 0;
  logic [LVL_W-1:0] m_lvl = '0;
  logic [N_SRC-1:0] m_pend = '0, m_latch = '0;
  logic [TS_W-1:0] m_stamp = '0;

  function automatic logic [NREG-1:0] therm(input logic [LVL_W-1:0] l);
    logic [NREG-1:0] t;
    for (int r = 0; r < NREG; r++) t[r] = (r <= int'(l));
    return t;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_step = 0; m_tmp = 0; m_alert = 0; m_lvl = '0;
      m_pend = '0; m_latch = '0; m_stamp = '0;
    end else begin
      logic [N_SRC-1:0] a;
      logic [LVL_W-1:0] lm;
      logic go;
      a = tin & ~mask;
      lm = herase ? hlvl : '0;
      for (int i = 0; i < N_SRC; i++)
        if (a[i] && lvl_cfg[i*LVL_W +: LVL_W] > lm) lm = lvl_cfg[i*LVL_W +: LVL_W];
      go = (a != '0) && !m_alert;
      case (m_step)
        0: begin
          if (lclr && a == '0) begin m_latch = '0; m_alert = 0; end
          else if (m_alert) m_latch |= a;
          m_pend = go ? a : '0;
          if (go || herase) begin m_step = 1; m_tmp = go; m_lvl = lm; end
        end
        1: begin m_pend |= a; if (m_alert) m_latch |= a; m_step = 2; end
        2: begin m_pend |= a; if (m_alert) m_latch |= a; m_step = m_tmp ? 3 : 0; end
        3: begin m_latch = m_latch | m_pend | a; m_pend |= a; m_step = 4; end
        4: begin m_latch |= a; m_pend |= a; m_alert = 1; m_step = 5; end
        default: begin m_latch |= a; m_pend |= a; m_stamp = tbv; m_step = 0; end
      endcase
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    logic [NREG-1:0] ek, er;
    ek = (m_step == 1) ? therm(m_lvl) : '0;
    er = (m_step == 2 && ext_en) ? therm(m_lvl) : '0;
    vecs++;
    if (key_wipe !== ek) begin errs++; $display("FAIL R2/R7 key_wipe act=%h exp=%h", key_wipe, ek); end
    if (ram_wipe !== er) begin errs++; $display("FAIL R3 ram_wipe act=%h exp=%h", ram_wipe, er); end
    if (latch_q !== m_latch) begin errs++; $display("FAIL R4/R11 latch_q act=%h exp=%h", latch_q, m_latch); end
    if (alert !== m_alert) begin errs++; $display("FAIL R5/R10 alert act=%b exp=%b", alert, m_alert); end
    if (stamp_q !== m_stamp) begin errs++; $display("FAIL R6 stamp_q act=%h exp=%h", stamp_q, m_stamp); end
    if (busy !== (m_step != 0)) begin errs++; $display("FAIL R6/R9 busy act=%b exp=%b", busy, m_step != 0); end
  end

  task automatic chk(input string tag, input logic [31:0] a, input logic [31:0] e);
    vecs++;
    if (a !== e) begin errs++; $display("FAIL %s act=%h exp=%h", tag, a, e); end
  endtask

  task automatic nxt(input int n = 1);
    for (int k = 0; k < n; k++) begin @(negedge clk); #1; end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    errs++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    logic [TS_W-1:0] es;
    // levels: s0=1 s1=0 s2=2 s3=3 s4=0 s5=3 s6=1 s7=0 s8=2
    lvl_cfg = {2'd2, 2'd0, 2'd1, 2'd3, 2'd0, 2'd3, 2'd2, 2'd0, 2'd1};
    mask = 9'h020;
    nxt(3); rst_n = 1'b1; nxt(1);
    // R1 reset state
    chk("R1 outputs", {key_wipe, ram_wipe, latch_q, alert, busy}, 0);
    chk("R1 stamp", stamp_q, 0);

    // single pulse on source 0 (level 1), RAM wipe enabled
    tin = 9'h001; nxt();
    chk("R2 key_wipe", key_wipe, 4'b0011);
    tin = '0; nxt();
    chk("R3 ram_wipe", ram_wipe, 4'b0011);
    nxt();
    chk("R4 latch before capture", latch_q, 0);
    nxt();
    chk("R4 latch_q", latch_q, 9'h001);
    nxt(); es = tbv;
    chk("R5 alert", alert, 1);
    nxt();
    chk("R6 stamp_q", stamp_q, es);
    chk("R6 busy done", busy, 0);

    // clear while the source is held: ignored
    tin = 9'h001; nxt(); lclr = 1'b1; nxt(); lclr = 1'b0;
    chk("R10 clear ignored alert", alert, 1);
    chk("R10 clear ignored latch", latch_q, 9'h001);
    tin = '0; nxt(); lclr = 1'b1; nxt(); lclr = 1'b0;
    chk("R10 clear accepted", {latch_q, alert}, 0);

    // masked external source 0 (bit 5)
    tin = 9'h020; nxt(3);
    chk("R8 masked no busy", busy, 0);
    chk("R8 masked no latch", latch_q, 0);
    tin = '0; nxt();

    // two sources, widest level wins; RAM wipe disabled
    ext_en = 1'b0; tin = 9'h00A; nxt();
    chk("R7 widest level", key_wipe, 4'b1111);
    nxt();
    chk("R3 ram disabled", ram_wipe, 0);
    tin = '0; nxt(4);
    chk("R4 two sources", latch_q, 9'h00A);
    lclr = 1'b1; nxt(); lclr = 1'b0; ext_en = 1'b1;

    // arrival during the wipe steps
    tin = 9'h002; nxt();
    chk("R7 level zero", key_wipe, 4'b0001);
    nxt(); tin = 9'h042; nxt(2);
    chk("R11 late source latched", latch_q, 9'h042);
    nxt(); es = tbv; nxt();
    chk("R11 stamp first event", stamp_q, es);
    nxt();
    chk("R11 no restart", busy, 0);

    // arrival while the alert is held in idle
    tin = 9'h046; nxt(2);
    chk("R11 frozen or", latch_q, 9'h046);
    chk("R11 frozen no sequence", busy, 0);
    chk("R11 stamp unchanged", stamp_q, es);
    tin = '0; nxt(); lclr = 1'b1; nxt(); lclr = 1'b0;

    // host erase request
    herase = 1'b1; hlvl = 2'd2; nxt(); herase = 1'b0;
    chk("R9 host key", key_wipe, 4'b0111);
    nxt();
    chk("R9 host ram", ram_wipe, 4'b0111);
    nxt();
    chk("R9 host short", busy, 0);
    chk("R9 host no alert", {latch_q, alert}, 0);
    chk("R9 host no stamp", stamp_q, es);
    nxt(3);
    finish_run();
  end
endmodule